// File: doc/BRIEF.md
# Direct-Mode Receive FIFO Burst Reader

This block is the read side of a slave port on an asynchronous 16-bit parallel host bus, modelled synchronously to a local clock. When the direct-mode select input is high during a read, the block skips the usual register decode and answers every read from a receive FIFO that holds 32-bit words. The address is ignored apart from bit 1. The host holds chip select and read strobe low for the whole burst and toggles address bit 1 to step through the data, one 16-bit half at a time.

A burst opens when chip select and read strobe are both low, and it closes as soon as either one rises. The two strobes may move in any order. Each FIFO word is sent as two halves, and the word is popped only once the host has moved past its second half. The block samples an endian select input like an address line. When it is high, the block sends the halves in the opposite order and swaps the two bytes inside each half. If the host reads while the FIFO is empty, the block returns zero and sets a sticky underrun flag.

The data bus is driven only inside a direct-mode burst. A separate output-enable signal shows when it is driven.

Top module: `fifo_burst_reader`

## Requirements
- R1: After a synchronous reset (rstN low at a clock edge), underrun is 0. With the strobes idle, busOe, busData and fifoPop are all 0.
- R2: busOe is 1 only in a cycle where csN is 0, rdN is 0 and fifoSel is 1. In every other cycle busOe is 0, busData is 0 and fifoPop is 0.
- R3: In the first cycle of a burst, with endianSwap 0, busData carries bits [15:0] of the FIFO head word. The level of addrA1 in that cycle is taken as the reference.
- R4: A toggle is a burst cycle where addrA1 differs from its value in the previous cycle. The cycle after a toggle shows the other half of the word (bits [31:16] after the low half). A toggle while the high half is shown raises fifoPop for exactly that one cycle, and the next cycle shows the low half of the next word.
- R5: If a burst ends (csN or rdN high, in either order) before the toggle after the high half, no pop happens. The next burst starts again at the low half of the same word.
- R6: While addrA1 holds its level inside a burst, the shown half does not change and fifoPop stays 0.
- R7: With endianSwap 1, the first half of a word W is {W[23:16], W[31:24]} and the second half is {W[7:0], W[15:8]}. Pop timing is the same as in R4.
- R8: A burst cycle with fifoEmpty 1 shows busData 0. It does not pop and does not advance the half. From the next cycle on, underrun is 1 and stays 1 until a reset.
- R9: A burst can run for any number of words. Toggling on every cycle pops one word every second cycle, in FIFO order.
- R10: With fifoSel 0, reads do not pop, do not drive the bus and do not set underrun, even when the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock that samples the bus |
| rstN | input | 1 | Synchronous reset, active low |
| csN | input | 1 | Chip select, active low |
| rdN | input | 1 | Read strobe, active low |
| fifoSel | input | 1 | Direct FIFO mode select, sampled like an address line |
| addrA1 | input | 1 | Address bit 1; each toggle steps the data |
| endianSwap | input | 1 | 1 = swap half order and bytes within halves |
| fifoWord | input | 2*BUS_W | Head word of the receive FIFO |
| fifoEmpty | input | 1 | Receive FIFO holds no word |
| busData | output | BUS_W | Read data onto the host bus |
| busOe | output | 1 | busData is driven |
| fifoPop | output | 1 | Remove the head word at this clock edge |
| underrun | output | 1 | Sticky flag: a direct read found the FIFO empty |

## Verification
The bench aims at the mid-word burst end. A design that pops on the last strobe edge instead of on the next toggle would lose the high half of that word when the host resumes. Steady addrA1 levels and the first cycle of a burst are exercised to catch a reader that advances on strobe edges or on the opening level. The bench also covers the swapped byte layout, which a wrong lane selection would scramble, and reads that run the FIFO dry, where a careless design pops a word that is not there or clears the flag early. Reads with fifoSel low and the FIFO empty show whether a design lets the underrun flag or the pop escape outside direct mode.

// File: rtl/fifo_burst_pkg.sv
package fifo_burst_pkg;

  // Strobes passed from the burst control to the datapath each cycle
  typedef struct packed {
    logic drive;        // direct-mode read in progress, bus driven
    logic upperHalf;    // present the second half of the ordered word
    logic popWord;      // head word fully presented, remove it
    logic markUnderrun; // a direct read met an empty FIFO
  } burst_strobes_t;

endpackage

// File: rtl/fifo_burst_ctrl.sv
module fifo_burst_ctrl
  import fifo_burst_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           csN,
  input  logic           rdN,
  input  logic           fifoSel,
  input  logic           addrA1,
  input  logic           fifoEmpty,
  output burst_strobes_t strobes
);

  logic active;
  logic inBurst;
  logic lastA1;
  logic halfSel;
  logic toggled;
  logic advance;

  // A burst lasts while both strobes are low in direct mode
  assign active  = !csN && !rdN && fifoSel;
  // First cycle of a burst only captures the reference level of A1
  assign toggled = active && inBurst && (addrA1 != lastA1);
  assign advance = toggled && !fifoEmpty;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inBurst <= 1'b0;
      lastA1  <= 1'b0;
      halfSel <= 1'b0;
    end else begin
      inBurst <= active;
      lastA1  <= addrA1;
      if (!active) begin
        halfSel <= 1'b0;
      end else if (advance) begin
        halfSel <= !halfSel;
      end
    end
  end

  always_comb begin
    strobes              = '0;
    strobes.drive        = active;
    strobes.upperHalf    = halfSel;
    strobes.popWord      = advance && halfSel;
    strobes.markUnderrun = active && fifoEmpty;
  end

endmodule

// File: rtl/fifo_burst_dpath.sv
module fifo_burst_dpath
  import fifo_burst_pkg::*;
#(
  parameter int BUS_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  burst_strobes_t       strobes,
  input  logic [2*BUS_W-1:0]   fifoWord,
  input  logic                 endianSwap,
  input  logic                 fifoEmpty,
  output logic [BUS_W-1:0]     busData,
  output logic                 busOe,
  output logic                 fifoPop,
  output logic                 underrun
);

  localparam int WORD_W = 2 * BUS_W;
  localparam int NBYTES = WORD_W / 8;

  logic [WORD_W-1:0] swapped;
  logic [WORD_W-1:0] ordered;
  logic [BUS_W-1:0]  lane;
  logic              underrunQ;

  // Full byte reversal of the word; splitting it yields swapped halves
  // whose bytes are also reversed
  for (genvar b = 0; b < NBYTES; b++) begin : g_rev
    assign swapped[b*8 +: 8] = fifoWord[(NBYTES-1-b)*8 +: 8];
  end

  assign ordered = endianSwap ? swapped : fifoWord;
  assign lane    = strobes.upperHalf ? ordered[WORD_W-1:BUS_W] : ordered[BUS_W-1:0];

  assign busData  = (strobes.drive && !fifoEmpty) ? lane : '0;
  assign busOe    = strobes.drive;
  assign fifoPop  = strobes.popWord;
  assign underrun = underrunQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      underrunQ <= 1'b0;
    end else if (strobes.markUnderrun) begin
      underrunQ <= 1'b1;
    end
  end

endmodule

// File: rtl/fifo_burst_reader.sv
module fifo_burst_reader
  import fifo_burst_pkg::*;
#(
  parameter int BUS_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 csN,
  input  logic                 rdN,
  input  logic                 fifoSel,
  input  logic                 addrA1,
  input  logic                 endianSwap,
  input  logic [2*BUS_W-1:0]   fifoWord,
  input  logic                 fifoEmpty,
  output logic [BUS_W-1:0]     busData,
  output logic                 busOe,
  output logic                 fifoPop,
  output logic                 underrun
);

  burst_strobes_t strobes;

  fifo_burst_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .csN       (csN),
    .rdN       (rdN),
    .fifoSel   (fifoSel),
    .addrA1    (addrA1),
    .fifoEmpty (fifoEmpty),
    .strobes   (strobes)
  );

  fifo_burst_dpath #(.BUS_W(BUS_W)) dpath_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .fifoWord   (fifoWord),
    .endianSwap (endianSwap),
    .fifoEmpty  (fifoEmpty),
    .busData    (busData),
    .busOe      (busOe),
    .fifoPop    (fifoPop),
    .underrun   (underrun)
  );

endmodule

// File: rtl/fifo_burst_reader_chk.sv
module fifo_burst_reader_chk #(
  parameter int BUS_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             csN,
  input logic             rdN,
  input logic             fifoSel,
  input logic             addrA1,
  input logic             fifoEmpty,
  input logic [BUS_W-1:0] busData,
  input logic             busOe,
  input logic             fifoPop,
  input logic             underrun
);

  p_oe_window_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(!csN && !rdN && fifoSel) |-> (!busOe && !fifoPop && busData == '0));

  p_pop_on_toggle_r4: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |-> (addrA1 != $past(addrA1)));

  p_pop_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |=> !fifoPop);

  p_pop_in_burst_r5: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |-> (busOe && $past(busOe)));

  p_no_pop_empty_r8: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |-> !fifoEmpty);

  p_empty_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busOe && fifoEmpty) |-> (busData == '0));

  p_underrun_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    underrun |=> underrun);

  p_no_pop_outside_r10: assert property (@(posedge clk) disable iff (!rstN)
    !fifoSel |-> !fifoPop);

endmodule

bind fifo_burst_reader fifo_burst_reader_chk #(.BUS_W(BUS_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .csN       (csN),
  .rdN       (rdN),
  .fifoSel   (fifoSel),
  .addrA1    (addrA1),
  .fifoEmpty (fifoEmpty),
  .busData   (busData),
  .busOe     (busOe),
  .fifoPop   (fifoPop),
  .underrun  (underrun)
);

// File: tb/fifo_burst_reader_tb_top.sv
module fifo_burst_reader_tb_top;

  localparam int BUS_W = 16;
  localparam int DEPTH = 64;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              csN = 1'b1;
  logic              rdN = 1'b1;
  logic              fifoSel = 1'b0;
  logic              addrA1 = 1'b0;
  logic              endianSwap = 1'b0;
  logic [31:0]       fifoWord;
  logic              fifoEmpty;
  logic [BUS_W-1:0]  busData;
  logic              busOe;
  logic              fifoPop;
  logic              underrun;

  always #5 clk = !clk;

  // Bench FIFO
  logic [31:0] mem [DEPTH];
  int          rdPtr = 0;
  int          fillCnt = 0;

  assign fifoEmpty = (rdPtr >= fillCnt);
  assign fifoWord  = mem[rdPtr % DEPTH];

  always @(posedge clk) begin
    if (fifoPop) rdPtr <= rdPtr + 1;
  end

  fifo_burst_reader #(.BUS_W(BUS_W)) dut_i (
    .clk        (clk),
    .rstN       (rstN),
    .csN        (csN),
    .rdN        (rdN),
    .fifoSel    (fifoSel),
    .addrA1     (addrA1),
    .endianSwap (endianSwap),
    .fifoWord   (fifoWord),
    .fifoEmpty  (fifoEmpty),
    .busData    (busData),
    .busOe      (busOe),
    .fifoPop    (fifoPop),
    .underrun   (underrun)
  );

  typedef struct {
    logic [15:0] data;
    logic        oe;
    logic        pop;
    logic        und;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   checkCnt = 0;
  int   failCnt  = 0;
  bit   done     = 0;

  // Reference model state, driven only from the requirements
  int  expIdx   = 0;
  bit  mHalf    = 0;
  bit  mPrevAct = 0;
  bit  mPrevA1  = 0;
  bit  mUnder   = 0;

  task automatic drive(input bit rst, input bit cs, input bit rd, input bit sel,
                       input bit a1, input bit endi, input string tag);
    exp_t        e;
    bit          act;
    bit          emp;
    bit          tog;
    logic [31:0] w;
    logic [31:0] o;
    @(negedge clk);
    rstN = !rst; csN = cs; rdN = rd; fifoSel = sel; addrA1 = a1; endianSwap = endi;
    act = !cs && !rd && sel;
    emp = (expIdx >= fillCnt);
    tog = act && mPrevAct && (a1 != mPrevA1);
    w = mem[expIdx % DEPTH];
    o = endi ? {w[7:0], w[15:8], w[23:16], w[31:24]} : w;
    e.oe   = act;
    e.data = (act && !emp) ? (mHalf ? o[31:16] : o[15:0]) : 16'h0;
    e.pop  = tog && mHalf && !emp;
    e.und  = mUnder;
    e.tag  = tag;
    q.push_back(e);
    if (rst) begin
      mPrevAct = 0; mPrevA1 = 0; mHalf = 0; mUnder = 0;
    end else begin
      if (act && emp) mUnder = 1;
      if (!act) mHalf = 0;
      else if (tog && !emp) begin
        if (mHalf) begin expIdx++; mHalf = 0; end
        else mHalf = 1;
      end
      mPrevAct = act;
      mPrevA1  = a1;
    end
  endtask

  task automatic readCyc(input bit a1, input bit endi, input string tag);
    drive(0, 0, 0, 1, a1, endi, tag);
  endtask

  task automatic idle(input string tag);
    drive(0, 1, 1, 1, 0, 0, tag);
  endtask

  // Monitor: compare each expected item in the cycle it was driven
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checkCnt++;
        if (busData !== e.data || busOe !== e.oe || fifoPop !== e.pop || underrun !== e.und) begin
          failCnt++;
          $display("FAIL %s: data=%h oe=%b pop=%b und=%b expected data=%h oe=%b pop=%b und=%b",
                   e.tag, busData, busOe, fifoPop, underrun, e.data, e.oe, e.pop, e.und);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = {8'(8'h10 + i), 8'(8'h40 + i), 8'(8'h70 + i), 8'(8'hC0 + i)};
    end
    fillCnt = 4;

    // R1: reset state
    drive(1, 1, 1, 0, 0, 0, "R1");
    drive(1, 1, 1, 0, 0, 0, "R1");
    idle("R1");

    // R3, R4, R6: basic burst
    readCyc(0, 0, "R3");
    readCyc(1, 0, "R4");
    readCyc(1, 0, "R4");
    readCyc(1, 0, "R6");
    readCyc(0, 0, "R4");
    readCyc(0, 0, "R4");
    drive(0, 1, 0, 1, 0, 0, "R2");
    idle("R2");

    // R5: end mid-word, strobes in both orders
    readCyc(1, 0, "R5");
    readCyc(0, 0, "R5");
    readCyc(0, 0, "R5");
    drive(0, 0, 1, 1, 0, 0, "R5");
    idle("R5");
    drive(0, 1, 0, 1, 0, 0, "R2");
    readCyc(0, 0, "R5");
    readCyc(1, 0, "R5");
    readCyc(1, 0, "R5");
    readCyc(0, 0, "R5");
    readCyc(0, 0, "R5");
    idle("R5");

    // R10: no direct mode
    for (int k = 0; k < 4; k++) drive(0, 0, 0, 0, k[0], 0, "R10");
    idle("R10");

    // R7: swapped layout
    readCyc(0, 1, "R7");
    readCyc(1, 1, "R7");
    readCyc(1, 1, "R7");
    readCyc(0, 1, "R7");
    readCyc(0, 1, "R7");
    idle("R7");

    // R9: long burst toggling every cycle
    fillCnt = 24;
    readCyc(1, 0, "R9");
    for (int k = 0; k < 40; k++) readCyc(k[0], 0, "R9");
    idle("R9");

    // R8: drain and underrun
    readCyc(0, 0, "R8");
    readCyc(1, 0, "R8");
    readCyc(1, 0, "R8");
    readCyc(0, 0, "R8");
    readCyc(0, 0, "R8");
    readCyc(1, 0, "R8");
    readCyc(1, 0, "R8");
    idle("R8");
    drive(0, 0, 0, 0, 0, 0, "R8");
    fillCnt = expIdx + 2;
    readCyc(0, 0, "R8");
    readCyc(1, 0, "R8");
    readCyc(1, 0, "R8");
    idle("R8");
    drive(1, 1, 1, 0, 0, 0, "R8");
    idle("R1");

    // R10: empty FIFO outside direct mode sets nothing
    fillCnt = expIdx;
    drive(0, 0, 0, 0, 0, 0, "R10");
    drive(0, 0, 0, 0, 1, 0, "R10");
    idle("R10");

    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
    $finish;
  end

endmodule